// File: doc/BRIEF.md
# Pipelined Compare, Subtract and Multiply Unit

This block is the arithmetic helper that a small stack machine's control sequencer calls for two-operand work. It subtracts, tests two words for equality, and orders them with less-than and less-or-equal, each in a signed and an unsigned form. It also multiplies, keeping the low word of the product. Every comparison comes from one shared subtractor: the difference word and its carry, overflow and zero flags are enough to form all six results.

The sequencer raises `start_i` for one cycle with an opcode and two operands. Later it sees `done_o` for one cycle, with the answer on `result_o`. The parameter `BIN_STAGES` inserts 0, 1 or 2 register stages into the subtract and compare path. This lets the clock run faster at the cost of whole cycles per operation. The completion pulse moves by exactly that many cycles. `MUL_PIPE` chooses between a single-cycle multiply and a three-stage multiply. Only one operation is in flight at a time. While one is in flight, `busy_o` is high and new start requests are dropped.

Top module: `cmp_sub_unit`

## Requirements
- R1: Opcode 0 returns `a_i - b_i` modulo 2^DATA_W.
- R2: Opcode 1 returns the full-width value 1 when the operands are equal and 0 otherwise.
- R3: Opcode 2 returns 1 when `a_i < b_i` as two's-complement numbers, else 0.
- R4: Opcode 3 returns 1 when `a_i < b_i` as unsigned numbers, else 0.
- R5: Opcode 4 (signed) and opcode 5 (unsigned) return 1 when `a_i <= b_i`, else 0.
- R6: For opcodes other than 6, `done_o` is high for exactly one cycle, 1 + BIN_STAGES cycles after the cycle in which the start was accepted.
- R7: A start is accepted only when `busy_o` is low. `busy_o` is high from the cycle after acceptance up to the cycle before `done_o`. A start raised while busy has no effect on any later result or completion, and `busy_o` and `done_o` are never high together.
- R8: Opcode 6 returns the low DATA_W bits of `a_i * b_i`. `done_o` follows the accepted start by 1 cycle when MUL_PIPE is 0 and by 3 cycles when MUL_PIPE is 1.
- R9: While `rst_n` is low, `done_o` and `busy_o` are low and `result_o` is zero.
- R10: Opcode 7 returns zero with the latency of R6.
- R11: `result_o` keeps its value in every cycle in which `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, sampled with op_i, a_i and b_i |
| op_i | input | 3 | Operation code (0 sub, 1 eq, 2 lt signed, 3 lt unsigned, 4 le signed, 5 le unsigned, 6 mul, 7 zero) |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| busy_o | output | 1 | An accepted operation has not yet completed |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | Result, valid with done_o and held afterwards |

## Verification
A wrong flag register in the middle stage shows up as a wrong comparison word in the same cycle as the completion pulse. A stuck valid bit in any stage shows up at once as a completion pulse that arrives at the wrong cycle, repeats, or never comes. If the busy logic lets a dropped request through, the port shows an extra completion pulse or an overwritten result within 1 + BIN_STAGES cycles. Operands at the signed boundary (0x80000000 against 0x7FFFFFFF, and all-ones against zero) are driven so that a mixed-up carry, overflow or sign term shows up in both orderings.

// File: rtl/csu_pkg.sv
package csu_pkg;

   localparam int unsigned OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      CSU_SUB = 3'd0,
      CSU_EQ  = 3'd1,
      CSU_LTS = 3'd2,
      CSU_LTU = 3'd3,
      CSU_LES = 3'd4,
      CSU_LEU = 3'd5,
      CSU_MUL = 3'd6,
      CSU_NOP = 3'd7
   } csu_op_e;

   // flags produced by the shared subtractor a + ~b + 1
   typedef struct packed {
      logic zero;   // difference is all zeros
      logic carry;  // carry out, set when a >= b unsigned
      logic ovf;    // two's-complement overflow of the difference
   } csu_flags_t;

endpackage

// File: rtl/csu_sub_core.sv
module csu_sub_core #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]   a_i,
   input  logic [DATA_W-1:0]   b_i,
   output logic [DATA_W-1:0]   diff_o,
   output csu_pkg::csu_flags_t flags_o
);

   localparam int unsigned MSB = DATA_W - 1;

   logic [DATA_W:0] sum;

   always_comb begin
      sum           = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};
      diff_o        = sum[MSB:0];
      flags_o.zero  = (sum[MSB:0] == '0);
      flags_o.carry = sum[DATA_W];
      flags_o.ovf   = (a_i[MSB] ^ b_i[MSB]) & (sum[MSB] ^ a_i[MSB]);
   end

endmodule

// File: rtl/csu_cmp_sel.sv
module csu_cmp_sel #(
   parameter int unsigned DATA_W = 32
) (
   input  csu_pkg::csu_op_e    op_i,
   input  logic [DATA_W-1:0]   diff_i,
   input  csu_pkg::csu_flags_t flags_i,
   output logic [DATA_W-1:0]   res_o
);
   import csu_pkg::*;

   localparam int unsigned MSB = DATA_W - 1;

   logic lt_s, lt_u, eq;

   always_comb begin
      eq   = flags_i.zero;
      lt_s = diff_i[MSB] ^ flags_i.ovf;
      lt_u = ~flags_i.carry;
      unique case (op_i)
         CSU_SUB: res_o = diff_i;
         CSU_EQ:  res_o = {{MSB{1'b0}}, eq};
         CSU_LTS: res_o = {{MSB{1'b0}}, lt_s};
         CSU_LTU: res_o = {{MSB{1'b0}}, lt_u};
         CSU_LES: res_o = {{MSB{1'b0}}, lt_s | eq};
         CSU_LEU: res_o = {{MSB{1'b0}}, lt_u | eq};
         default: res_o = '0;
      endcase
   end

endmodule

// File: rtl/csu_bin_path.sv
module csu_bin_path #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned BIN_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                launch_i,
   input  csu_pkg::csu_op_e    op_i,
   input  logic [DATA_W-1:0]   a_i,
   input  logic [DATA_W-1:0]   b_i,
   output logic                inflight_o,
   output logic                vld_o,
   output logic [DATA_W-1:0]   res_o
);
   import csu_pkg::*;

   logic              sel_vld;
   logic [DATA_W-1:0] sel_res;

   generate
      if (BIN_STAGES == 0) begin : g_s0
         logic [DATA_W-1:0] diff;
         csu_flags_t        flags;

         csu_sub_core #(.DATA_W(DATA_W)) u_sub (
            .a_i(a_i), .b_i(b_i), .diff_o(diff), .flags_o(flags));
         csu_cmp_sel #(.DATA_W(DATA_W)) u_sel (
            .op_i(op_i), .diff_i(diff), .flags_i(flags), .res_o(sel_res));

         assign sel_vld    = launch_i;
         assign inflight_o = 1'b0;
      end else begin : g_sn
         // operand register stage, present for 1 and 2 extra cycles
         logic              v1;
         csu_op_e           op1;
         logic [DATA_W-1:0] a1, b1;
         logic [DATA_W-1:0] diff;
         csu_flags_t        flags;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v1  <= 1'b0;
               op1 <= CSU_SUB;
               a1  <= '0;
               b1  <= '0;
            end else begin
               v1 <= launch_i;
               if (launch_i) begin
                  op1 <= op_i;
                  a1  <= a_i;
                  b1  <= b_i;
               end
            end
         end

         csu_sub_core #(.DATA_W(DATA_W)) u_sub (
            .a_i(a1), .b_i(b1), .diff_o(diff), .flags_o(flags));

         if (BIN_STAGES == 1) begin : g_s1
            csu_cmp_sel #(.DATA_W(DATA_W)) u_sel (
               .op_i(op1), .diff_i(diff), .flags_i(flags), .res_o(sel_res));
            assign sel_vld    = v1;
            assign inflight_o = v1;
         end else begin : g_s2
            // difference and flag register stage, cuts adder from selector
            logic              v2;
            csu_op_e           op2;
            logic [DATA_W-1:0] diff2;
            csu_flags_t        flags2;

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  v2     <= 1'b0;
                  op2    <= CSU_SUB;
                  diff2  <= '0;
                  flags2 <= '0;
               end else begin
                  v2 <= v1;
                  if (v1) begin
                     op2    <= op1;
                     diff2  <= diff;
                     flags2 <= flags;
                  end
               end
            end

            csu_cmp_sel #(.DATA_W(DATA_W)) u_sel (
               .op_i(op2), .diff_i(diff2), .flags_i(flags2), .res_o(sel_res));
            assign sel_vld    = v2;
            assign inflight_o = v1 | v2;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         res_o <= '0;
      end else begin
         vld_o <= sel_vld;
         if (sel_vld) res_o <= sel_res;
      end
   end

endmodule

// File: rtl/csu_mul_path.sv
module csu_mul_path #(
   parameter int unsigned DATA_W   = 32,
   parameter bit          MUL_PIPE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic              inflight_o,
   output logic              vld_o,
   output logic [DATA_W-1:0] res_o
);

   logic              fin_vld;
   logic [DATA_W-1:0] fin_res;

   generate
      if (!MUL_PIPE) begin : g_flat
         assign fin_vld    = launch_i;
         assign fin_res    = a_i * b_i;
         assign inflight_o = 1'b0;
      end else begin : g_pipe
         logic              v1, v2;
         logic [DATA_W-1:0] a1, b1, p2;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v1 <= 1'b0;
               v2 <= 1'b0;
               a1 <= '0;
               b1 <= '0;
               p2 <= '0;
            end else begin
               v1 <= launch_i;
               v2 <= v1;
               if (launch_i) begin
                  a1 <= a_i;
                  b1 <= b_i;
               end
               if (v1) p2 <= a1 * b1;
            end
         end

         assign fin_vld    = v2;
         assign fin_res    = p2;
         assign inflight_o = v1 | v2;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         res_o <= '0;
      end else begin
         vld_o <= fin_vld;
         if (fin_vld) res_o <= fin_res;
      end
   end

endmodule

// File: rtl/cmp_sub_unit.sv
module cmp_sub_unit #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned BIN_STAGES = 0,
   parameter bit          MUL_PIPE   = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic [csu_pkg::OP_W-1:0]    op_i,
   input  logic [DATA_W-1:0]           a_i,
   input  logic [DATA_W-1:0]           b_i,
   output logic                        busy_o,
   output logic                        done_o,
   output logic [DATA_W-1:0]           result_o
);
   import csu_pkg::*;

   generate
      if (BIN_STAGES > 2) begin : g_bad_stages
         $error("cmp_sub_unit: BIN_STAGES must be 0, 1 or 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("cmp_sub_unit: DATA_W must be at least 2");
      end
   endgenerate

   csu_op_e           op;
   logic              accept, go_bin, go_mul;
   logic              bin_busy, mul_busy, bin_vld, mul_vld;
   logic [DATA_W-1:0] bin_res, mul_res;
   logic              last_mul;

   assign op     = csu_op_e'(op_i);
   assign busy_o = bin_busy | mul_busy;
   assign accept = start_i & ~busy_o;
   assign go_mul = accept & (op == CSU_MUL);
   assign go_bin = accept & (op != CSU_MUL);

   csu_bin_path #(.DATA_W(DATA_W), .BIN_STAGES(BIN_STAGES)) u_bin (
      .clk(clk), .rst_n(rst_n), .launch_i(go_bin), .op_i(op),
      .a_i(a_i), .b_i(b_i), .inflight_o(bin_busy),
      .vld_o(bin_vld), .res_o(bin_res));

   csu_mul_path #(.DATA_W(DATA_W), .MUL_PIPE(MUL_PIPE)) u_mul (
      .clk(clk), .rst_n(rst_n), .launch_i(go_mul),
      .a_i(a_i), .b_i(b_i), .inflight_o(mul_busy),
      .vld_o(mul_vld), .res_o(mul_res));

   // remembers which path finished last so the held result stays put
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 last_mul <= 1'b0;
      else if (bin_vld | mul_vld) last_mul <= mul_vld;
   end

   assign done_o = bin_vld | mul_vld;

   always_comb begin
      if (mul_vld)      result_o = mul_res;
      else if (bin_vld) result_o = bin_res;
      else              result_o = last_mul ? mul_res : bin_res;
   end

endmodule

// File: rtl/csu_chk.sv
module csu_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned BIN_STAGES = 0,
   parameter bit          MUL_PIPE   = 1'b0
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start_i,
   input logic [csu_pkg::OP_W-1:0] op_i,
   input logic                     busy_o,
   input logic                     done_o,
   input logic [DATA_W-1:0]        result_o
);
   import csu_pkg::*;

   localparam int unsigned BIN_LAT = BIN_STAGES + 1;
   localparam int unsigned MUL_LAT = MUL_PIPE ? 3 : 1;

   logic take_bin, take_mul;
   assign take_bin = start_i && !busy_o && (op_i != CSU_MUL);
   assign take_mul = start_i && !busy_o && (op_i == CSU_MUL);

   a_r6_bin_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $past(take_bin, BIN_LAT) |-> done_o);

   a_r8_mul_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $past(take_mul, MUL_LAT) |-> done_o);

   a_r7_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   a_r7_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (take_bin && BIN_LAT > 1) |=> busy_o);

   a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r9_reset_quiet: assert (!done_o && !busy_o && result_o == '0);
      end
   end

endmodule

bind cmp_sub_unit csu_chk #(
   .DATA_W(DATA_W), .BIN_STAGES(BIN_STAGES), .MUL_PIPE(MUL_PIPE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
   .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/cmp_sub_unit_tb.sv
`timescale 1ns/1ps
module cmp_sub_unit_tb;

   localparam int NDUT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] a = '0, b = '0;
   logic        done [NDUT];
   logic        busy [NDUT];
   logic [31:0] res  [NDUT];

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   // dut 0: no extra stages, flat multiply
   cmp_sub_unit #(.DATA_W(32), .BIN_STAGES(0), .MUL_PIPE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
      .busy_o(busy[0]), .done_o(done[0]), .result_o(res[0]));
   // dut 1: one extra stage, pipelined multiply
   cmp_sub_unit #(.DATA_W(32), .BIN_STAGES(1), .MUL_PIPE(1'b1)) u_dut_s1 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
      .busy_o(busy[1]), .done_o(done[1]), .result_o(res[1]));
   // dut 2: two extra stages, flat multiply
   cmp_sub_unit #(.DATA_W(32), .BIN_STAGES(2), .MUL_PIPE(1'b0)) u_dut_s2 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
      .busy_o(busy[2]), .done_o(done[2]), .result_o(res[2]));

   function automatic int lat_of(input int d, input logic [2:0] o);
      if (o == 3'd6) return (d == 1) ? 3 : 1;
      return d + 1;
   endfunction

   function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
      case (o)
         3'd0: return x - y;
         3'd1: return {31'd0, x == y};
         3'd2: return {31'd0, $signed(x) <  $signed(y)};
         3'd3: return {31'd0, x < y};
         3'd4: return {31'd0, $signed(x) <= $signed(y)};
         3'd5: return {31'd0, x <= y};
         3'd6: return x * y;
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] o);
      case (o)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4, 3'd5: return "R5";
         3'd6: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int d,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s dut%0d t=%0t act=%h exp=%h", tag, d, $time, act, exp);
      end
   endtask

   // one operation; checks pulse cycle, busy window and result on every dut
   task automatic run_op(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
      logic [31:0] exp;
      exp = model(o, x, y);
      @(negedge clk);
      op = o; a = x; b = y; start = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         for (int d = 0; d < NDUT; d++) begin
            int L;
            L = lat_of(d, o);
            chk(done[d] == (k == L), (o == 3'd6) ? "R8" : "R6", d,
                {31'd0, done[d]}, {31'd0, k == L});
            chk(busy[d] == (k < L), "R7", d, {31'd0, busy[d]}, {31'd0, k < L});
            if (k == L) chk(res[d] == exp, tag_of(o), d, res[d], exp);
            if (k > L)  chk(res[d] == exp, "R11", d, res[d], exp);
         end
      end
   endtask

   task automatic t_reset;
      for (int d = 0; d < NDUT; d++) begin
         chk(!done[d] && !busy[d] && res[d] == '0, "R9", d, res[d], 32'd0);
      end
   endtask

   task automatic t_subtract;  // R1
      run_op(3'd0, 32'd5, 32'd3);
      run_op(3'd0, 32'd0, 32'd1);
      run_op(3'd0, 32'h8000_0000, 32'd1);
      run_op(3'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
   endtask

   task automatic t_compare;  // R2 R3 R4 R5
      logic [31:0] xs [6] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'd5, 32'd0, 32'hFFFF_FFFF, 32'h8000_0000};
      logic [31:0] ys [6] = '{32'h7FFF_FFFF, 32'h8000_0000, 32'd5, 32'hFFFF_FFFF, 32'd0, 32'h8000_0000};
      for (int o = 1; o <= 5; o++) begin
         for (int i = 0; i < 6; i++) run_op(3'(o), xs[i], ys[i]);
      end
   endtask

   task automatic t_multiply;  // R8
      run_op(3'd6, 32'd3, 32'd5);
      run_op(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run_op(3'd6, 32'h8000_0000, 32'd2);
      run_op(3'd6, 32'h1234_5678, 32'h9ABC_DEF0);
      run_op(3'd6, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
   endtask

   task automatic t_reserved;  // R10
      run_op(3'd7, 32'hDEAD_BEEF, 32'd1);
   endtask

   // R7: a second request one cycle after the first is dropped by busy duts
   task automatic t_ignore;
      bit          e_done [NDUT][6];
      logic [31:0] e_res  [NDUT][6];
      for (int k = 1; k <= 5; k++) begin
         e_done[0][k] = (k == 1) || (k == 2);
         e_res[0][k]  = (k == 1) ? 32'd999 : 32'd1;
         e_done[1][k] = (k == 2);
         e_res[1][k]  = 32'd999;
         e_done[2][k] = (k == 3);
         e_res[2][k]  = 32'd999;
      end
      @(negedge clk);
      op = 3'd0; a = 32'd1000; b = 32'd1; start = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         if (k == 1) begin op = 3'd3; a = 32'd1; b = 32'd2; end
         if (k == 2) start = 1'b0;
         for (int d = 0; d < NDUT; d++) begin
            chk(done[d] == e_done[d][k], "R7", d, {31'd0, done[d]}, {31'd0, e_done[d][k]});
            if (k >= d + 1) chk(res[d] == e_res[d][k], "R7", d, res[d], e_res[d][k]);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_subtract();
      t_compare();
      t_multiply();
      t_reserved();
      t_ignore();
      run_op(3'd0, 32'd7, 32'd9);
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule